// File: doc/BRIEF.md
# Flash Command Interface and Status Register

This block is the bus-facing control logic of a byte-programmable, block-erasable flash device. It takes bus write cycles qualified by active-low chip-enable and write-enable, decodes 8-bit command codes and tracks the current read mode. Memory changes follow only a two-cycle sequence: a setup code and then a data or confirm cycle. An accepted sequence starts a small write-engine model. That model stays busy for a fixed number of clock cycles and then pulses a commit strobe toward the storage array. The storage array itself is outside this block.

Reads are served from one output. In array mode it passes the array data input straight through. In every other mode it shows an 8-bit status byte. That byte carries a ready flag and three sticky error flags: erase failure, program failure and program-voltage failure. Once any error flag is set, later program or erase attempts are refused until software issues a clear. Three conditions stop an operation before it ends: the program-voltage-valid input falling, the supply-lockout input rising, or the powerdown pin going low. The powerdown pin also returns all state to its initial values.

Top module: `flash_cmd_iface`

## Requirements
- R1: A bus write is taken only in a cycle where both `ce_n` and `we_n` are low, and only once per low period. A write is not taken when either strobe is high, or when the strobes are already low while powerdown or lockout is released.
- R2: After `rst`, or while `pwr_dn_n` is low, the mode is array mode and all error flags are 0. While `pwr_dn_n` is low, `dout` reads 0x00, writes are ignored, and a running operation ends without a commit.
- R3: Code 0xFF selects array mode, where `dout` equals `array_q`. Code 0x70 selects status mode. Any code that is not a command leaves the mode unchanged.
- R4: Setup code 0x40 or 0x10 followed by a data byte starts a program operation. It stays busy for exactly WR_CYC cycles, with status bit 7 = 0. It then pulses `commit_wr` once, with `wr_data` equal to the data byte. Afterwards the block stays in status mode.
- R5: Setup code 0x20 followed by 0xD0 starts an erase. It stays busy for exactly ER_CYC cycles and then pulses `commit_er` once.
- R6: An erase setup followed by any code other than 0xD0 sets status bits 5 and 4, enters status mode, and starts nothing.
- R7: If `vpp_ok` falls while busy, the operation stops in the next cycle without a commit. Status bit 3 is set, together with bit 4 for a program or bit 5 for an erase.
- R8: If `vpp_ok` is low at the data or confirm cycle, no operation starts. Bit 3 and the operation's bit (4 or 5) are set.
- R9: While any of status bits 5, 4 or 3 is set, a program attempt is refused and sets bit 4, and an erase attempt is refused and sets bit 5. Code 0x50 clears bits 5, 4 and 3 and leaves the mode unchanged.
- R10: The status byte has bit 7 = ready, bit 5 = erase error, bit 4 = program error, bit 3 = voltage error. Bits 6, 2, 1 and 0 always read 0, so the idle value is 0x80.
- R11: Bus writes that arrive while an operation is busy are ignored.
- R12: While `vdd_low` is high, the mode is forced to array mode and writes are ignored. A busy operation stops without a commit and sets its own error bit (4 or 5), but not bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| pwr_dn_n | input | 1 | Active-low powerdown/reset pin |
| vdd_low | input | 1 | Supply below lockout level |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| din | input | 8 | Bus write data / command code |
| vpp_ok | input | 1 | Program voltage valid |
| array_q | input | 8 | Data read from the storage array |
| dout | output | 8 | Read data: array data or status byte |
| commit_wr | output | 1 | One-cycle pulse: program operation completed |
| commit_er | output | 1 | One-cycle pulse: erase operation completed |
| wr_data | output | 8 | Byte latched at the program data cycle |

## Verification
The bench sweeps all 256 command codes from both array mode and status mode. A decoder that treats an unknown code as "read array", or that drops out of status mode, gives the wrong read value. Holding both strobes low for several cycles catches a level-sensitive capture, because the setup code would be taken again as data and would start a program. Aborts are driven mid-operation by voltage loss, powerdown and lockout. A design that still committed, set the wrong flag, or left a flag set after clear shows a wrong status byte or an extra commit count. Busy lengths are counted cycle by cycle against WR_CYC and ER_CYC, and commands are sent while busy to confirm that they change nothing.

// File: rtl/fci_pkg.sv
package fci_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [BYTE_W-1:0] CMD_READ_STATUS = 8'h70;
    localparam logic [BYTE_W-1:0] CMD_CLEAR_SR    = 8'h50;
    localparam logic [BYTE_W-1:0] CMD_PROG_A      = 8'h40;
    localparam logic [BYTE_W-1:0] CMD_PROG_B      = 8'h10;
    localparam logic [BYTE_W-1:0] CMD_ERASE       = 8'h20;
    localparam logic [BYTE_W-1:0] CMD_CONFIRM     = 8'hD0;

    typedef enum logic [1:0] {
        MD_ARRAY  = 2'd0,
        MD_STATUS = 2'd1,
        MD_PSETUP = 2'd2,
        MD_ESETUP = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2
    } op_e;

    typedef struct packed {
        logic ers;
        logic prg;
        logic vpp;
    } err_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } bus_cyc_t;

    function automatic logic [BYTE_W-1:0] pack_status(logic ready, err_t e);
        return {ready, 1'b0, e.ers, e.prg, e.vpp, 3'b000};
    endfunction

    function automatic logic is_prog_setup(logic [BYTE_W-1:0] c);
        return (c == CMD_PROG_A) || (c == CMD_PROG_B);
    endfunction

endpackage

// File: rtl/fci_bus_capture.sv
module fci_bus_capture
    import fci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              block,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [BYTE_W-1:0] din,
    output bus_cyc_t          cyc
);
    logic act;
    logic act_q;

    assign act = !ce_n && !we_n;

    // Held high while blocked so strobes already low at release are not taken.
    always_ff @(posedge clk) begin
        if (rst || block) begin
            act_q <= 1'b1;
        end else begin
            act_q <= act;
        end
    end

    always_comb begin
        cyc.valid = act && !act_q && !block;
        cyc.data  = din;
    end

    // R1
    single_accept_chk: assert property (@(posedge clk) disable iff (rst)
        cyc.valid |=> !cyc.valid);

endmodule

// File: rtl/fci_wsm.sv
module fci_wsm
    import fci_pkg::*;
#(
    parameter int WR_CYC = 8,
    parameter int ER_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic halt,
    input  logic vpp_ok,
    input  logic start,
    input  op_e  start_op,
    output logic busy,
    output op_e  run_op,
    output logic done,
    output logic abort,
    output logic halted
);
    localparam int MAX_CYC = (WR_CYC > ER_CYC) ? WR_CYC : ER_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] ER_LOAD = CNT_W'(ER_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || halt) begin
            busy   <= 1'b0;
            run_op <= OP_NONE;
            cnt    <= '0;
        end else if (busy) begin
            if (!vpp_ok || cnt == '0) begin
                busy   <= 1'b0;
                run_op <= OP_NONE;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else if (start) begin
            busy   <= 1'b1;
            run_op <= start_op;
            cnt    <= (start_op == OP_PROG) ? WR_LOAD : ER_LOAD;
        end
    end

    assign done   = busy && !halt && vpp_ok && (cnt == '0);
    assign abort  = busy && !halt && !vpp_ok;
    assign halted = busy && halt;

    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !halt) |=> busy);

    // R7
    vpp_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !vpp_ok && !halt) |=> !busy);

    // R11
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done || abort || halt));

endmodule

// File: rtl/fci_ctrl.sv
module fci_ctrl
    import fci_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pd,
    input  logic              vdd_low,
    input  bus_cyc_t          cyc,
    input  logic              vpp_ok,
    input  logic              busy,
    input  logic              abort,
    input  logic              halted,
    input  op_e               run_op,
    output mode_e             mode,
    output err_t              errs,
    output logic              start,
    output op_e               start_op,
    output logic [BYTE_W-1:0] wr_data
);
    mode_e             mode_n;
    err_t              errs_n;
    logic [BYTE_W-1:0] wr_data_n;
    logic              take;
    logic              idle_mode;
    logic              clr_hit;
    logic              any_err;

    assign take      = cyc.valid && !busy && !vdd_low;
    assign idle_mode = (mode == MD_ARRAY) || (mode == MD_STATUS);
    assign clr_hit   = take && idle_mode && (cyc.data == CMD_CLEAR_SR);
    assign any_err   = errs.ers || errs.prg || errs.vpp;

    always_comb begin
        mode_n    = mode;
        errs_n    = errs;
        wr_data_n = wr_data;
        start     = 1'b0;
        start_op  = OP_NONE;

        if (abort) begin
            errs_n.vpp = 1'b1;
            if (run_op == OP_PROG) errs_n.prg = 1'b1;
            else                   errs_n.ers = 1'b1;
        end
        if (halted) begin
            if (run_op == OP_PROG) errs_n.prg = 1'b1;
            else                   errs_n.ers = 1'b1;
        end

        if (vdd_low) begin
            mode_n = MD_ARRAY;
        end else if (take) begin
            unique case (mode)
                MD_ARRAY, MD_STATUS: begin
                    if (cyc.data == CMD_READ_ARRAY) begin
                        mode_n = MD_ARRAY;
                    end else if (cyc.data == CMD_READ_STATUS) begin
                        mode_n = MD_STATUS;
                    end else if (cyc.data == CMD_CLEAR_SR) begin
                        errs_n = '0;
                    end else if (is_prog_setup(cyc.data)) begin
                        mode_n = MD_PSETUP;
                    end else if (cyc.data == CMD_ERASE) begin
                        mode_n = MD_ESETUP;
                    end
                end
                MD_PSETUP: begin
                    mode_n    = MD_STATUS;
                    wr_data_n = cyc.data;
                    if (any_err) begin
                        errs_n.prg = 1'b1;
                    end else if (!vpp_ok) begin
                        errs_n.vpp = 1'b1;
                        errs_n.prg = 1'b1;
                    end else begin
                        start    = 1'b1;
                        start_op = OP_PROG;
                    end
                end
                MD_ESETUP: begin
                    mode_n = MD_STATUS;
                    if (cyc.data != CMD_CONFIRM) begin
                        errs_n.ers = 1'b1;
                        errs_n.prg = 1'b1;
                    end else if (any_err) begin
                        errs_n.ers = 1'b1;
                    end else if (!vpp_ok) begin
                        errs_n.vpp = 1'b1;
                        errs_n.ers = 1'b1;
                    end else begin
                        start    = 1'b1;
                        start_op = OP_ERASE;
                    end
                end
                default: mode_n = MD_ARRAY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || pd) begin
            mode    <= MD_ARRAY;
            errs    <= '0;
            wr_data <= '0;
        end else begin
            mode    <= mode_n;
            errs    <= errs_n;
            wr_data <= wr_data_n;
        end
    end

    // R2
    pd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        pd |=> (mode == MD_ARRAY && !errs.ers && !errs.prg && !errs.vpp));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (any_err && !pd && !clr_hit) |=> (errs.ers || errs.prg || errs.vpp));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !pd && !vdd_low) |=> (mode == $past(mode)));

    // R12
    lockout_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (vdd_low && !pd) |=> (mode == MD_ARRAY));

endmodule

// File: rtl/flash_cmd_iface.sv
module flash_cmd_iface
    import fci_pkg::*;
#(
    parameter int WR_CYC = 8,
    parameter int ER_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_dn_n,
    input  logic              vdd_low,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [BYTE_W-1:0] din,
    input  logic              vpp_ok,
    input  logic [BYTE_W-1:0] array_q,
    output logic [BYTE_W-1:0] dout,
    output logic              commit_wr,
    output logic              commit_er,
    output logic [BYTE_W-1:0] wr_data
);
    logic     pd;
    bus_cyc_t cyc;
    mode_e    mode;
    err_t     errs;
    logic     start;
    op_e      start_op;
    logic     busy;
    op_e      run_op;
    logic     done;
    logic     abort;
    logic     halted;

    assign pd = !pwr_dn_n;

    fci_bus_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .block (pd || vdd_low),
        .ce_n  (ce_n),
        .we_n  (we_n),
        .din   (din),
        .cyc   (cyc)
    );

    fci_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .pd       (pd),
        .vdd_low  (vdd_low),
        .cyc      (cyc),
        .vpp_ok   (vpp_ok),
        .busy     (busy),
        .abort    (abort),
        .halted   (halted),
        .run_op   (run_op),
        .mode     (mode),
        .errs     (errs),
        .start    (start),
        .start_op (start_op),
        .wr_data  (wr_data)
    );

    fci_wsm #(
        .WR_CYC (WR_CYC),
        .ER_CYC (ER_CYC)
    ) u_wsm (
        .clk      (clk),
        .rst      (rst),
        .halt     (pd || vdd_low),
        .vpp_ok   (vpp_ok),
        .start    (start),
        .start_op (start_op),
        .busy     (busy),
        .run_op   (run_op),
        .done     (done),
        .abort    (abort),
        .halted   (halted)
    );

    assign commit_wr = done && (run_op == OP_PROG);
    assign commit_er = done && (run_op == OP_ERASE);

    always_comb begin
        if (pd) begin
            dout = '0;
        end else if (mode == MD_ARRAY) begin
            dout = array_q;
        end else begin
            dout = pack_status(!busy, errs);
        end
    end

    // R4
    commit_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(commit_wr && commit_er));

    // R7
    no_commit_after_abort_chk: assert property (@(posedge clk) disable iff (rst)
        abort |=> !(commit_wr || commit_er));

endmodule

// File: tb/tb_flash_cmd_iface.sv
module tb_flash_cmd_iface;
    localparam int WR = 4;
    localparam int ER = 10;
    localparam logic [7:0] AQ = 8'hA5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_dn_n = 1'b1;
    logic vdd_low = 1'b0;
    logic ce_n = 1'b1;
    logic we_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic vpp_ok = 1'b1;
    logic [7:0] array_q = AQ;
    logic [7:0] dout;
    logic commit_wr, commit_er;
    logic [7:0] wr_data;

    int tests = 0;
    int fails = 0;
    int n_wr = 0;
    int n_er = 0;
    logic [7:0] last_wr = 8'h00;

    always #4 clk = ~clk;

    flash_cmd_iface #(.WR_CYC(WR), .ER_CYC(ER)) dut (
        .clk(clk), .rst(rst), .pwr_dn_n(pwr_dn_n), .vdd_low(vdd_low),
        .ce_n(ce_n), .we_n(we_n), .din(din), .vpp_ok(vpp_ok),
        .array_q(array_q), .dout(dout), .commit_wr(commit_wr),
        .commit_er(commit_er), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (commit_wr) begin
            n_wr = n_wr + 1;
            last_wr = wr_data;
        end
        if (commit_er) n_er = n_er + 1;
    end

    task automatic chk(string tag, int act, int exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(logic [7:0] d);
        @(negedge clk);
        din = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic pd_pulse();
        @(negedge clk);
        pwr_dn_n = 1'b0;
        tick(2);
        pwr_dn_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ready(output int cycles);
        cycles = 0;
        while (dout[7] == 1'b0 && cycles < 1000) begin
            cycles = cycles + 1;
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 150000);
        tests = tests + 1;
        fails = fails + 1;
        $display("FAIL watchdog act=hung exp=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cyc;
        int w0;
        int e0;
        tick(3);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state: array mode, then status idle 0x80
        chk("R2 reset mode", dout, AQ);
        bus_wr(8'h70);
        chk("R2 reset status", dout, 8'h80);

        // R1 one strobe high: no write taken
        pd_pulse();
        @(negedge clk); din = 8'h70; ce_n = 1'b0; we_n = 1'b1;
        tick(3); ce_n = 1'b1; we_n = 1'b0; tick(3); we_n = 1'b1; tick(1);
        chk("R1 strobe gating", dout, AQ);
        // R1 strobes held low: only one acceptance
        w0 = n_wr;
        @(negedge clk); din = 8'h40; ce_n = 1'b0; we_n = 1'b0;
        tick(4); ce_n = 1'b1; we_n = 1'b1; tick(WR + 3);
        chk("R1 held low single take", n_wr, w0);
        // R1 strobes low across powerdown release: not taken
        pd_pulse();
        @(negedge clk); pwr_dn_n = 1'b0; din = 8'h70; ce_n = 1'b0; we_n = 1'b0;
        tick(2); pwr_dn_n = 1'b1; tick(3); ce_n = 1'b1; we_n = 1'b1; tick(1);
        chk("R1 low at release", dout, AQ);

        // R3 sweep of all codes from array and from status mode
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 256; c++) begin
                logic [7:0] code;
                int exp;
                code = c[7:0];
                pd_pulse();
                if (s == 1) bus_wr(8'h70);
                bus_wr(code);
                if (code == 8'hFF) exp = AQ;
                else if (code == 8'h70 || code == 8'h40 || code == 8'h10 || code == 8'h20) exp = 8'h80;
                else exp = (s == 1) ? 8'h80 : AQ;
                chk("R3 code sweep", dout, exp);
                if (code == 8'h40 || code == 8'h10) begin
                    w0 = n_wr;
                    bus_wr(8'h5A);
                    wait_ready(cyc);
                    chk("R4 sweep commit", n_wr, w0 + 1);
                    chk("R4 sweep data", last_wr, 8'h5A);
                end
                if (code == 8'h20) begin
                    bus_wr(8'h00);
                    // R6 bad confirm sets bits 5 and 4
                    chk("R6 bad confirm", dout, 8'hB0);
                end
            end
        end

        // R4 program sequences with several data bytes
        for (int k = 0; k < 8; k++) begin
            logic [7:0] d;
            d = 8'(k * 37 + 1);
            pd_pulse();
            w0 = n_wr;
            bus_wr((k % 2 == 0) ? 8'h40 : 8'h10);
            bus_wr(d);
            chk("R4 busy status", dout, 8'h00);
            wait_ready(cyc);
            chk("R4 busy length", cyc, WR);
            chk("R4 commit count", n_wr, w0 + 1);
            chk("R4 commit data", last_wr, d);
            chk("R4 stays status", dout, 8'h80);
        end

        // R5 erase; R11 commands during busy ignored
        pd_pulse();
        w0 = n_wr; e0 = n_er;
        bus_wr(8'h20); bus_wr(8'hD0);
        chk("R5 busy status", dout, 8'h00);
        wait_ready(cyc);
        chk("R5 busy length", cyc, ER);
        chk("R5 commit count", n_er, e0 + 1);
        bus_wr(8'h20); bus_wr(8'hD0);
        bus_wr(8'hFF); bus_wr(8'h40); bus_wr(8'h55);
        wait_ready(cyc);
        chk("R11 mode after busy", dout, 8'h80);
        chk("R11 no extra program", n_wr, w0);

        // R7 program abort on voltage loss; R9 refusal and clear
        pd_pulse();
        w0 = n_wr; e0 = n_er;
        bus_wr(8'h40); bus_wr(8'h33);
        tick(1); vpp_ok = 1'b0; tick(1);
        chk("R7 program abort", dout, 8'h98);
        vpp_ok = 1'b1; tick(WR + 2);
        chk("R7 no commit", n_wr, w0);
        bus_wr(8'h40); bus_wr(8'h11);
        chk("R9 program refused", dout, 8'h98);
        bus_wr(8'h20); bus_wr(8'hD0);
        chk("R9 erase refused", dout, 8'hB8);
        // R10 unused bits read zero
        chk("R10 zero bits", dout & 8'h47, 0);
        tick(ER + 2);
        chk("R9 no commits", n_wr + n_er, w0 + e0);
        bus_wr(8'h50);
        chk("R9 clear", dout, 8'h80);
        bus_wr(8'h40); bus_wr(8'h22);
        wait_ready(cyc);
        chk("R9 program after clear", n_wr, w0 + 1);

        // R7 erase abort
        pd_pulse();
        e0 = n_er;
        bus_wr(8'h20); bus_wr(8'hD0);
        tick(3); vpp_ok = 1'b0; tick(1);
        chk("R7 erase abort", dout, 8'hA8);
        vpp_ok = 1'b1; tick(ER);
        chk("R7 erase no commit", n_er, e0);

        // R8 voltage low at start
        pd_pulse();
        w0 = n_wr; e0 = n_er;
        vpp_ok = 1'b0;
        bus_wr(8'h10); bus_wr(8'h77);
        chk("R8 program not started", dout, 8'h98);
        pd_pulse();
        bus_wr(8'h20); bus_wr(8'hD0);
        chk("R8 erase not started", dout, 8'hA8);
        vpp_ok = 1'b1; tick(ER + 2);
        chk("R8 no commits", n_wr + n_er, w0 + e0);

        // R2 powerdown mid-erase
        pd_pulse();
        e0 = n_er;
        bus_wr(8'h20); bus_wr(8'hD0);
        tick(2); pwr_dn_n = 1'b0; tick(1);
        chk("R2 dout during powerdown", dout, 8'h00);
        bus_wr(8'h70);
        pwr_dn_n = 1'b1; @(negedge clk);
        chk("R2 array after release", dout, AQ);
        bus_wr(8'h70);
        chk("R2 status cleared", dout, 8'h80);
        tick(ER + 2);
        chk("R2 no commit", n_er, e0);

        // R12 lockout mid-program
        pd_pulse();
        w0 = n_wr;
        bus_wr(8'h40); bus_wr(8'h44);
        tick(1); vdd_low = 1'b1; tick(1);
        chk("R12 array during lockout", dout, AQ);
        bus_wr(8'h70);
        chk("R12 write ignored", dout, AQ);
        vdd_low = 1'b0; tick(1);
        chk("R12 array after lockout", dout, AQ);
        bus_wr(8'h70);
        chk("R12 program bit only", dout, 8'h90);
        chk("R12 no commit", n_wr, w0);

        // R3 array data pass-through with other values
        pd_pulse();
        array_q = 8'h3C; tick(1);
        chk("R3 array pass", dout, 8'h3C);
        array_q = 8'h00; tick(1);
        chk("R3 array pass zero", dout, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule